// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns a train of single-cycle strobes into two phase signals for circuits that must never have both of their switches closed together. A toggle register halves the strobe rate into a 50% duty reference. The reference and its inverse each feed one phase gate. Each gate may assert only while its own side of the reference is active and the far end of the other phase's delay chain is low.

Each phase has a shift chain of `2*HALF_DEPTH` register stages. The visible phase is taken from the midpoint of the chain. The far end is fed back to block the other gate. As a result, a phase can only rise after the other phase's fall has run through the whole of that phase's chain. This leaves a both-low gap at every handover, and a longer `HALF_DEPTH` gives a wider gap.

Strobes must be at least `4*HALF_DEPTH+3` cycles apart for the timing below to hold. Closer strobes are allowed but may shrink the phases to nothing. Even then the two phases are never high together.

Top module: `noc_two_phase`

## Requirements
- R1: `phase_a` and `phase_b` are never both high in the same cycle, for any strobe sequence, including strobes closer than `4*HALF_DEPTH+3` cycles.
- R2: While `rst` is high (sampled at a clock edge), `phase_a`, `phase_b` and `ref_clk` are all 0 from the next cycle on.
- R3: A strobe on `pulse_in` sampled at an edge inverts `ref_clk` in the cycle after that edge. With no strobe, `ref_clk` holds its value.
- R4: After reset is released, `phase_a` goes high exactly `HALF_DEPTH` cycles later. `phase_b` stays low until the first strobe has driven `ref_clk` to 1.
- R5: When `ref_clk` falls from 1 to 0, `phase_b` falls `HALF_DEPTH` cycles later and `phase_a` rises `3*HALF_DEPTH` cycles later.
- R6: When `ref_clk` rises from 0 to 1, `phase_a` falls `HALF_DEPTH` cycles later and `phase_b` rises `3*HALF_DEPTH` cycles later.
- R7: With legal strobe spacing, every rise of either phase is preceded by exactly `2*HALF_DEPTH` consecutive cycles with both phases low. This is never fewer than `HALF_DEPTH` cycles.
- R8: With legal spacing, the time from one `phase_a` rise to the next equals the sum of the two strobe intervals between them. This makes the output period two strobe intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Single-cycle strobe that advances the reference |
| phase_a | output | 1 | First phase, active while the reference is low |
| phase_b | output | 1 | Second phase, active while the reference is high |
| ref_clk | output | 1 | Divided-by-two reference from the toggle register |

## Verification
A stuck or mis-reset toggle register shows on `ref_clk` one cycle after the strobe that should have moved it. After that, both phases are out of step with the strobe timing. A wrong tap or a short chain moves a phase edge away from the `HALF_DEPTH` or `3*HALF_DEPTH` latency of R5 and R6, and this is visible at the first handover. Broken feedback appears as a shrunken both-low gap or, at worst, an overlap. An overlap is flagged in the very cycle it happens.

// File: rtl/noc_pkg.sv
package noc_pkg;

  // Stages in one side's full delay chain.
  function automatic int unsigned noc_chain_len(input int unsigned half);
    return 2 * half;
  endfunction

  // Both-low cycles between one phase falling and the other rising.
  function automatic int unsigned noc_gap_cycles(input int unsigned half);
    return 2 * half;
  endfunction

  // Smallest strobe interval for which full timing is guaranteed.
  function automatic int unsigned noc_min_spacing(input int unsigned half);
    return 4 * half + 3;
  endfunction

  // Saturation value for the both-low run counter.
  function automatic int unsigned noc_run_cap(input int unsigned half);
    return noc_gap_cycles(half) + 1;
  endfunction

endpackage

// File: rtl/noc_toggle.sv
module noc_toggle (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic ref_q
);

  always_ff @(posedge clk) begin
    if (rst)         ref_q <= 1'b0;
    else if (strobe) ref_q <= ~ref_q;
  end

  // R3: a strobe inverts the reference in the following cycle
  a_r3_strobe_flips: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (ref_q != $past(ref_q)));

  // R3: without a strobe the reference holds
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(ref_q));

endmodule

// File: rtl/noc_phase_side.sv
module noc_phase_side
  import noc_pkg::*;
#(
  parameter int unsigned HALF_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic want,      // reference level selecting this phase
  input  logic peer_fb,   // far end of the other side's chain
  output logic gate_on,   // combinational gate decision
  output logic tap,       // midpoint, the visible phase
  output logic fb_out     // far end, fed to the other gate
);

  localparam int unsigned CHAIN = noc_chain_len(HALF_DEPTH);

  logic [CHAIN-1:0] stage_q;

  assign gate_on = want & ~peer_fb;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[CHAIN-2:0], gate_on};
  end

  assign tap    = stage_q[HALF_DEPTH-1];
  assign fb_out = stage_q[CHAIN-1];

endmodule

// File: rtl/noc_spacing_guard.sv
module noc_spacing_guard
  import noc_pkg::*;
#(
  parameter int unsigned HALF_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic any_high,
  output logic legal_q,
  output logic [$clog2(noc_run_cap(HALF_DEPTH)+1)-1:0] low_run_q
);

  localparam int unsigned MIN_SP  = noc_min_spacing(HALF_DEPTH);
  localparam int unsigned SW      = $clog2(MIN_SP + 1);
  localparam int unsigned RUN_CAP = noc_run_cap(HALF_DEPTH);
  localparam int unsigned RW      = $clog2(RUN_CAP + 1);
  localparam logic [SW-1:0] SP_LIM  = SW'(MIN_SP);
  localparam logic [RW-1:0] RUN_LIM = RW'(RUN_CAP);

  logic [SW-1:0] since_q;

  // Cycles since the last strobe; reset counts as a strobe.
  always_ff @(posedge clk) begin
    if (rst)                  since_q <= '0;
    else if (strobe)          since_q <= '0;
    else if (since_q < SP_LIM) since_q <= since_q + 1'b1;
  end

  // Sticky flag: false once any strobe arrived too early.
  always_ff @(posedge clk) begin
    if (rst)                            legal_q <= 1'b1;
    else if (strobe && since_q < SP_LIM) legal_q <= 1'b0;
  end

  // Consecutive cycles with both phases low, saturating.
  always_ff @(posedge clk) begin
    if (rst)                   low_run_q <= '0;
    else if (any_high)         low_run_q <= '0;
    else if (low_run_q < RUN_LIM) low_run_q <= low_run_q + 1'b1;
  end

endmodule

// File: rtl/noc_two_phase.sv
module noc_two_phase
  import noc_pkg::*;
#(
  parameter int unsigned HALF_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic phase_a,
  output logic phase_b,
  output logic ref_clk
);

  localparam int unsigned RW = $clog2(noc_run_cap(HALF_DEPTH) + 1);
  localparam logic [RW-1:0] HALF_W = RW'(HALF_DEPTH);

  logic ref_q;
  logic gate_a, gate_b;
  logic fb_a, fb_b;
  logic legal_q;
  logic [RW-1:0] low_run_q;

  noc_toggle u_toggle (
    .clk    (clk),
    .rst    (rst),
    .strobe (pulse_in),
    .ref_q  (ref_q)
  );

  // Side A follows the inverted reference, so it leads after reset.
  noc_phase_side #(.HALF_DEPTH(HALF_DEPTH)) u_side_a (
    .clk     (clk),
    .rst     (rst),
    .want    (~ref_q),
    .peer_fb (fb_b),
    .gate_on (gate_a),
    .tap     (phase_a),
    .fb_out  (fb_a)
  );

  noc_phase_side #(.HALF_DEPTH(HALF_DEPTH)) u_side_b (
    .clk     (clk),
    .rst     (rst),
    .want    (ref_q),
    .peer_fb (fb_a),
    .gate_on (gate_b),
    .tap     (phase_b),
    .fb_out  (fb_b)
  );

  noc_spacing_guard #(.HALF_DEPTH(HALF_DEPTH)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .strobe    (pulse_in),
    .any_high  (phase_a | phase_b),
    .legal_q   (legal_q),
    .low_run_q (low_run_q)
  );

  assign ref_clk = ref_q;

  // R1: outputs never overlap
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(phase_a && phase_b));

  // R1: the two gates never open together
  a_r1_gates_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_a && gate_b));

  // R2: reset clears every output
  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (!phase_a && !phase_b && !ref_clk));

  // R7: each rise follows at least HALF_DEPTH both-low cycles
  a_r7_gap_before_rise: assert property (@(posedge clk) disable iff (rst || !legal_q)
    ($rose(phase_a) || $rose(phase_b)) |-> (low_run_q >= HALF_W));

endmodule

// File: tb/tb_noc_two_phase.sv
module tb_noc_two_phase;

  localparam int unsigned HD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic phase_a, phase_b, ref_clk;

  noc_two_phase #(.HALF_DEPTH(HD)) dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in),
    .phase_a(phase_a), .phase_b(phase_b), .ref_clk(ref_clk)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side restatement of the timing rules
  function automatic int fall_after(input int p); return p + 1 + int'(HD); endfunction
  function automatic int rise_after(input int p); return p + 1 + 3 * int'(HD); endfunction
  function automatic int want_gap(); return 2 * int'(HD); endfunction
  function automatic int legal_gap(); return 4 * int'(HD) + 3; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Pulse history and reference model
  int  p0 = 0, p2 = 0, p1 = 0;
  int  pcount = 0;
  bit  lp_ref = 1'b0;
  int  rel = 0;
  bit  timed = 1'b1;

  bit  pa_q = 1'b0, pb_q = 1'b0;
  int  run = 0;
  int  last_rise_a = 0;

  always @(negedge clk) begin
    if (rst) begin
      pa_q = 1'b0; pb_q = 1'b0; run = 0;
      if (cyc > 1) begin
        check(!phase_a && !phase_b && !ref_clk, "R2 outputs low in reset",
              {phase_a, phase_b, ref_clk}, 0);
      end
    end else begin
      check(!(phase_a && phase_b), "R1 no overlap", {phase_a, phase_b}, 0);
      if (timed) begin
        if (pcount > 0 && cyc == p0 + 1)
          check(ref_clk == lp_ref, "R3 reference flips after strobe", ref_clk, lp_ref);
        if (phase_a && !pa_q) begin
          if (pcount == 0) begin
            check(cyc == rel + int'(HD), "R4 first rise of phase_a", cyc, rel + int'(HD));
          end else begin
            check(lp_ref == 1'b0 && cyc == rise_after(p0), "R5 phase_a rise latency",
                  cyc, rise_after(p0));
            check(run == want_gap(), "R7 gap before phase_a", run, want_gap());
            if (pcount >= 3)
              check(cyc - last_rise_a == p0 - p2, "R8 phase_a period",
                    cyc - last_rise_a, p0 - p2);
          end
          last_rise_a = cyc;
        end
        if (!phase_a && pa_q)
          check(pcount > 0 && lp_ref == 1'b1 && cyc == fall_after(p0),
                "R6 phase_a fall latency", cyc, fall_after(p0));
        if (phase_b && !pb_q) begin
          check(pcount > 0 && lp_ref == 1'b1, "R4 phase_b waits for reference", pcount, 1);
          check(cyc == rise_after(p0), "R6 phase_b rise latency", cyc, rise_after(p0));
          check(run == want_gap(), "R7 gap before phase_b", run, want_gap());
        end
        if (!phase_b && pb_q)
          check(lp_ref == 1'b0 && cyc == fall_after(p0), "R5 phase_b fall latency",
                cyc, fall_after(p0));
      end
      run = (phase_a || phase_b) ? 0 : run + 1;
      pa_q = phase_a; pb_q = phase_b;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_once();
    @(negedge clk); #1;
    pulse_in = 1'b1;
    p2 = p1; p1 = p0; p0 = cyc;
    pcount++;
    lp_ref = ~lp_ref;
    @(negedge clk); #1;
    pulse_in = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1'b1;
    pulse_in = 1'b0;
    idle(4);
    #1;
    pcount = 0; lp_ref = 1'b0; timed = 1'b1;
    rst = 1'b0;
    rel = cyc;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    do_reset();
    idle(legal_gap() + 2);
    check(phase_a && !phase_b, "R4 phase_a leads after reset", {phase_a, phase_b}, 2);

    // Directed: strobes at exactly the minimum legal spacing
    for (int k = 0; k < 6; k++) begin
      strobe_once();
      idle(legal_gap() - 2);
    end
    idle(10);

    // Random legal spacing
    for (int k = 0; k < 40; k++) begin
      strobe_once();
      idle(legal_gap() - 2 + int'($urandom % 25));
    end
    idle(60);

    // Stress: strobes far too close; only overlap is judged
    @(negedge clk); #1;
    timed = 1'b0;
    for (int k = 0; k < 300; k++) begin
      pulse_in = ($urandom % 3) != 0;
      @(negedge clk); #1;
    end
    pulse_in = 1'b0;
    idle(5);

    // Reset mid-stream and resume legal operation
    do_reset();
    idle(2);
    check(!phase_b && !ref_clk, "R2 clean restart", {phase_b, ref_clk}, 0);
    idle(legal_gap());
    for (int k = 0; k < 8; k++) begin
      strobe_once();
      idle(legal_gap() + int'($urandom % 10));
    end
    idle(20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule